// File: doc/BRIEF.md
# Serial Receiver Loopback Entry Sequencer

This block sits on the tester side of a serial link and steers a receiver under test into loopback. It waits in an idle state until the error checker reports its first mismatch. That mismatch is the leading 1 of the receiver's low-frequency signalling, which the checker flags as an error. The block then raises a one-cycle trigger and turns the lane switch toward the burst generator. It counts burst-done pulses until the programmed count is reached; 400 is the normal setting. While the bursts are running, it preloads the equalisation-training pattern into the generator and sets the checker to expect that same pattern.

After the final burst, the switch goes back to the pattern generator. The training stages then run in a fixed order: the equalisation-training pattern first, then the first ordered set, then the second ordered set with its loopback bit raised. Each stage lasts for a programmable number of stage-done pulses. The sequence ends in the compliance stage. Here the generator sends the scrambled compliance pattern and the checker expects the same pattern back, so an error-free return shows that loopback was reached.

A per-stage watchdog, with a programmable limit, moves a stalled sequence into a sticky failure state. A synchronous restart returns the block to idle from any state.

Top module: `lpbk_entry_seq`

## Requirements
- R1: After reset, trig_out, sw_sel, lpbk_bit and fail_flag are 0, and pat_sel and exp_sel hold code 0 (no pattern).
- R2: In idle, a chk_err high on a clock edge gives trig_out high for exactly the following cycle, and sw_sel high (burst path) from that same cycle.
- R3: While sw_sel is high, pat_sel and exp_sel both hold code 1 (equalisation training), so the pattern is preloaded before the bursts end.
- R4: sw_sel stays high until the number of burst_done pulses equals burst_cfg (400 in normal use). On the edge of the pulse that reaches the count, sw_sel returns to 0 and pat_sel keeps code 1.
- R5: Each training stage advances after stage_reps stage_done pulses. The order of pat_sel codes is 1, then 2 (first ordered set), then 3 (second ordered set), then 4 (compliance). In the training stages, exp_sel equals pat_sel.
- R6: lpbk_bit is 1 exactly while pat_sel is code 3.
- R7: In the compliance stage, pat_sel and exp_sel are both code 4. They hold there, ignoring stage_done, until restart.
- R8: chk_err outside the idle state has no effect: trig_out stays 0 and the stage does not change.
- R9: If a burst or training stage runs for stage_tmo cycles without completing, the block enters failure. In failure, fail_flag is 1, sw_sel is 0, pat_sel and exp_sel are code 0, and it stays there (chk_err ignored) until restart.
- R10: restart high on an edge returns the block to idle from any state and clears fail_flag. A later chk_err starts a new entry.
- R11: A stage_tmo of 0 disables the watchdog.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| restart | input | 1 | Synchronous return to idle, clears failure |
| chk_err | input | 1 | First-error strobe from the error checker |
| burst_done | input | 1 | One pulse per burst sent by the burst generator |
| stage_done | input | 1 | One pulse per ordered-set repetition from the pattern generator |
| burst_cfg | input | BURST_W (9) | Burst count target (normally 400) |
| stage_reps | input | REP_W (8) | Repetitions per training stage |
| stage_tmo | input | TMO_W (16) | Watchdog limit in cycles per stage, 0 disables |
| trig_out | output | 1 | One-cycle trigger for the lane switch |
| sw_sel | output | 1 | 1 selects the burst generator, 0 the pattern generator |
| pat_sel | output | 3 | Generator pattern code (0 none, 1 equalisation, 2 first set, 3 second set, 4 compliance) |
| exp_sel | output | 3 | Checker expected-pattern code, same encoding |
| lpbk_bit | output | 1 | Loopback bit requested in the second ordered set |
| fail_flag | output | 1 | Sticky watchdog failure |

## Verification
The states hardest to reach from the ports are the exact burst boundary and a watchdog expiry that happens in the middle of training. For the boundary, the bench sends burst_done pulses one at a time and samples after the 399th and after the 400th. For the watchdog, the bench moves the block into a chosen stage and then holds back the completion pulses for longer than the limit. It then shows that the failure is sticky against further error strobes, and that only restart clears it. A run with the limit set to 0 then stays in the burst stage well beyond any finite limit.

// File: rtl/lpbk_pkg.sv
package lpbk_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_BURST = 3'd1,
    ST_TSEQ  = 3'd2,
    ST_TS1   = 3'd3,
    ST_TS2   = 3'd4,
    ST_CPAT  = 3'd5,
    ST_FAIL  = 3'd6
  } seq_state_t;

  localparam logic [2:0] PAT_NONE = 3'd0;
  localparam logic [2:0] PAT_TSEQ = 3'd1;
  localparam logic [2:0] PAT_TS1  = 3'd2;
  localparam logic [2:0] PAT_TS2  = 3'd3;
  localparam logic [2:0] PAT_CPAT = 3'd4;

  typedef struct packed {
    logic       trig;
    logic       sw;
    logic [2:0] pat;
    logic [2:0] expt;
    logic       lpbk;
    logic       fail;
  } seq_out_t;

  // Output image for a given state (trigger handled separately)
  function automatic seq_out_t decode_state(seq_state_t s);
    seq_out_t o;
    o = '0;
    case (s)
      ST_BURST: begin o.sw = 1'b1; o.pat = PAT_TSEQ; o.expt = PAT_TSEQ; end
      ST_TSEQ:  begin o.pat = PAT_TSEQ; o.expt = PAT_TSEQ; end
      ST_TS1:   begin o.pat = PAT_TS1;  o.expt = PAT_TS1;  end
      ST_TS2:   begin o.pat = PAT_TS2;  o.expt = PAT_TS2; o.lpbk = 1'b1; end
      ST_CPAT:  begin o.pat = PAT_CPAT; o.expt = PAT_CPAT; end
      ST_FAIL:  begin o.fail = 1'b1; end
      default:  o = '0;
    endcase
    return o;
  endfunction

endpackage

// File: rtl/lpbk_evt_cnt.sv
module lpbk_evt_cnt #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  input  logic [W-1:0] target,
  output logic         hit
);
  localparam int XW = W + 1;

  logic [W-1:0]  cnt;
  logic [XW-1:0] cnt_next;

  assign cnt_next = {1'b0, cnt} + XW'(1);
  // A target of 0 behaves as 1: the first event completes
  assign hit = inc && (cnt_next >= {1'b0, target});

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (inc) begin
      cnt <= cnt_next[W-1:0];
    end
  end
endmodule

// File: rtl/lpbk_stage_wdog.sv
module lpbk_stage_wdog #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         en,
  input  logic [W-1:0] limit,
  output logic         expired
);
  logic [W-1:0] cnt;
  logic         armed;

  assign armed   = (limit != '0);
  assign expired = en && armed && (cnt == limit);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (en && armed && (cnt != limit)) begin
      cnt <= cnt + W'(1);
    end
  end
endmodule

// File: rtl/lpbk_out_reg.sv
module lpbk_out_reg
  import lpbk_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  seq_out_t d,
  output seq_out_t q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else begin
      q <= d;
    end
  end
endmodule

// File: rtl/lpbk_entry_seq.sv
module lpbk_entry_seq
  import lpbk_pkg::*;
#(
  parameter int BURST_W = 9,
  parameter int REP_W   = 8,
  parameter int TMO_W   = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               restart,
  input  logic               chk_err,
  input  logic               burst_done,
  input  logic               stage_done,
  input  logic [BURST_W-1:0] burst_cfg,
  input  logic [REP_W-1:0]   stage_reps,
  input  logic [TMO_W-1:0]   stage_tmo,
  output logic               trig_out,
  output logic               sw_sel,
  output logic [2:0]         pat_sel,
  output logic [2:0]         exp_sel,
  output logic               lpbk_bit,
  output logic               fail_flag
);

  seq_state_t state, state_nxt;
  logic       in_train;
  logic       stage_chg;
  logic       burst_hit;
  logic       rep_hit;
  logic       tmo_hit;
  seq_out_t   out_d, out_q;

  assign in_train  = (state == ST_TSEQ) || (state == ST_TS1) || (state == ST_TS2);
  assign stage_chg = (state_nxt != state);

  lpbk_evt_cnt #(.W(BURST_W)) u_burst_cnt (
    .clk    (clk),
    .rst    (rst),
    .clr    (stage_chg),
    .inc    ((state == ST_BURST) && burst_done),
    .target (burst_cfg),
    .hit    (burst_hit)
  );

  lpbk_evt_cnt #(.W(REP_W)) u_rep_cnt (
    .clk    (clk),
    .rst    (rst),
    .clr    (stage_chg),
    .inc    (in_train && stage_done),
    .target (stage_reps),
    .hit    (rep_hit)
  );

  lpbk_stage_wdog #(.W(TMO_W)) u_wdog (
    .clk     (clk),
    .rst     (rst),
    .clr     (stage_chg),
    .en      ((state == ST_BURST) || in_train),
    .limit   (stage_tmo),
    .expired (tmo_hit)
  );

  always_comb begin
    state_nxt = state;
    if (restart) begin
      state_nxt = ST_IDLE;
    end else begin
      case (state)
        ST_IDLE:  if (chk_err) state_nxt = ST_BURST;
        ST_BURST: if (tmo_hit) state_nxt = ST_FAIL;
                  else if (burst_hit) state_nxt = ST_TSEQ;
        ST_TSEQ:  if (tmo_hit) state_nxt = ST_FAIL;
                  else if (rep_hit) state_nxt = ST_TS1;
        ST_TS1:   if (tmo_hit) state_nxt = ST_FAIL;
                  else if (rep_hit) state_nxt = ST_TS2;
        ST_TS2:   if (tmo_hit) state_nxt = ST_FAIL;
                  else if (rep_hit) state_nxt = ST_CPAT;
        ST_CPAT:  state_nxt = ST_CPAT;
        ST_FAIL:  state_nxt = ST_FAIL;
        default:  state_nxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
    end else begin
      state <= state_nxt;
    end
  end

  always_comb begin
    out_d      = decode_state(state_nxt);
    out_d.trig = (state == ST_IDLE) && chk_err && !restart;
  end

  lpbk_out_reg u_out (
    .clk (clk),
    .rst (rst),
    .d   (out_d),
    .q   (out_q)
  );

  assign trig_out  = out_q.trig;
  assign sw_sel    = out_q.sw;
  assign pat_sel   = out_q.pat;
  assign exp_sel   = out_q.expt;
  assign lpbk_bit  = out_q.lpbk;
  assign fail_flag = out_q.fail;

endmodule

// File: rtl/lpbk_entry_seq_chk.sv
module lpbk_entry_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       restart,
  input logic       trig_out,
  input logic       sw_sel,
  input logic [2:0] pat_sel,
  input logic [2:0] exp_sel,
  input logic       lpbk_bit,
  input logic       fail_flag
);

  a_r2_trig_single: assert property (@(posedge clk) disable iff (rst)
    trig_out |=> !trig_out);

  a_r2_trig_with_switch: assert property (@(posedge clk) disable iff (rst)
    trig_out |-> sw_sel);

  a_r3_burst_preload: assert property (@(posedge clk) disable iff (rst)
    sw_sel |-> (pat_sel == 3'd1 && exp_sel == 3'd1));

  a_r5_expect_tracks: assert property (@(posedge clk) disable iff (rst)
    (pat_sel != 3'd0) |-> (exp_sel == pat_sel));

  a_r5_ts1_order: assert property (@(posedge clk) disable iff (rst)
    (pat_sel == 3'd2 && !restart) |=> (pat_sel == 3'd2 || pat_sel == 3'd3 || pat_sel == 3'd0));

  a_r6_lpbk_only_ts2: assert property (@(posedge clk) disable iff (rst)
    lpbk_bit == (pat_sel == 3'd3));

  a_r7_final_hold: assert property (@(posedge clk) disable iff (rst)
    (pat_sel == 3'd4 && !restart) |=> (pat_sel == 3'd4));

  a_r9_fail_sticky: assert property (@(posedge clk) disable iff (rst)
    (fail_flag && !restart) |=> fail_flag);

  a_r9_fail_quiet: assert property (@(posedge clk) disable iff (rst)
    fail_flag |-> (!sw_sel && pat_sel == 3'd0 && !trig_out));

  a_r10_restart_idle: assert property (@(posedge clk) disable iff (rst)
    restart |=> (!fail_flag && !sw_sel && pat_sel == 3'd0 && !trig_out));

endmodule

bind lpbk_entry_seq lpbk_entry_seq_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .restart   (restart),
  .trig_out  (trig_out),
  .sw_sel    (sw_sel),
  .pat_sel   (pat_sel),
  .exp_sel   (exp_sel),
  .lpbk_bit  (lpbk_bit),
  .fail_flag (fail_flag)
);

// File: tb/tb_lpbk_entry_seq.sv
`timescale 1ns/1ps
module tb_lpbk_entry_seq;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       restart = 1'b0;
  logic       chk_err = 1'b0;
  logic       burst_done = 1'b0;
  logic       stage_done = 1'b0;
  logic [8:0] burst_cfg = 9'd400;
  logic [7:0] stage_reps = 8'd3;
  logic [15:0] stage_tmo = 16'd2000;
  logic       trig_out, sw_sel, lpbk_bit, fail_flag;
  logic [2:0] pat_sel, exp_sel;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  lpbk_entry_seq dut (
    .clk(clk), .rst(rst), .restart(restart), .chk_err(chk_err),
    .burst_done(burst_done), .stage_done(stage_done),
    .burst_cfg(burst_cfg), .stage_reps(stage_reps), .stage_tmo(stage_tmo),
    .trig_out(trig_out), .sw_sel(sw_sel), .pat_sel(pat_sel), .exp_sel(exp_sel),
    .lpbk_bit(lpbk_bit), .fail_flag(fail_flag)
  );

  task automatic chk(input string req, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic idle_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_err();
    chk_err = 1'b1; @(negedge clk); chk_err = 1'b0;
  endtask

  task automatic pulse_burst();
    burst_done = 1'b1; @(negedge clk); burst_done = 1'b0; @(negedge clk);
  endtask

  task automatic pulse_stage();
    stage_done = 1'b1; @(negedge clk); stage_done = 1'b0; @(negedge clk);
  endtask

  task automatic do_restart();
    restart = 1'b1; @(negedge clk); restart = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1; idle_cycles(3); rst = 1'b0; @(negedge clk);
    chk("R1 trig", trig_out, 0);  chk("R1 sw", sw_sel, 0);
    chk("R1 pat", pat_sel, 0);    chk("R1 exp", exp_sel, 0);
    chk("R1 lpbk", lpbk_bit, 0);  chk("R1 fail", fail_flag, 0);
  endtask

  // Full entry with 400 bursts and 3 repetitions per stage
  task automatic t_full_entry();
    burst_cfg = 9'd400; stage_reps = 8'd3; stage_tmo = 16'd2000;
    pulse_err();
    chk("R2 trig pulse", trig_out, 1); chk("R2 switch", sw_sel, 1);
    chk("R3 pat preload", pat_sel, 1); chk("R3 exp preload", exp_sel, 1);
    @(negedge clk);
    chk("R2 trig one cycle", trig_out, 0);
    for (int i = 0; i < 399; i++) pulse_burst();
    chk("R4 still bursting at 399", sw_sel, 1);
    pulse_burst();
    chk("R4 switch back at 400", sw_sel, 0);
    chk("R4 tseq first", pat_sel, 1);
    pulse_stage(); pulse_stage();
    chk("R5 tseq holds", pat_sel, 1);
    pulse_stage();
    chk("R5 ts1", pat_sel, 2); chk("R5 exp ts1", exp_sel, 2);
    chk("R6 no lpbk in ts1", lpbk_bit, 0);
    pulse_err();
    chk("R8 no trig in ts1", trig_out, 0); chk("R8 stage kept", pat_sel, 2);
    for (int i = 0; i < 3; i++) pulse_stage();
    chk("R5 ts2", pat_sel, 3); chk("R6 lpbk in ts2", lpbk_bit, 1);
    for (int i = 0; i < 3; i++) pulse_stage();
    chk("R7 compliance gen", pat_sel, 4); chk("R7 compliance exp", exp_sel, 4);
    chk("R6 lpbk off", lpbk_bit, 0);
    for (int i = 0; i < 5; i++) pulse_stage();
    pulse_err();
    chk("R7 holds final", pat_sel, 4); chk("R8 no trig final", trig_out, 0);
    do_restart();
    chk("R10 restart idle", pat_sel, 0);
  endtask

  task automatic t_timeout_ts1();
    burst_cfg = 9'd2; stage_reps = 8'd1; stage_tmo = 16'd50;
    pulse_err(); pulse_burst(); pulse_burst(); pulse_stage();
    chk("R5 ts1 reached", pat_sel, 2);
    idle_cycles(20);
    chk("R9 no early fail", fail_flag, 0);
    idle_cycles(40);
    chk("R9 fail set", fail_flag, 1); chk("R9 pat cleared", pat_sel, 0);
    chk("R9 sw cleared", sw_sel, 0);
    pulse_err(); idle_cycles(2);
    chk("R9 sticky", fail_flag, 1); chk("R9 no trig", trig_out, 0);
    do_restart();
    chk("R10 fail cleared", fail_flag, 0);
    pulse_err();
    chk("R10 re-entry", sw_sel, 1);
    do_restart();
  endtask

  task automatic t_tmo_disabled();
    burst_cfg = 9'd400; stage_tmo = 16'd0;
    pulse_err(); idle_cycles(500);
    chk("R11 no fail", fail_flag, 0); chk("R11 still bursting", sw_sel, 1);
    do_restart();
    chk("R10 idle from burst", sw_sel, 0);
  endtask

  task automatic t_short_burst();
    burst_cfg = 9'd5; stage_reps = 8'd1; stage_tmo = 16'd100;
    pulse_err();
    for (int i = 0; i < 4; i++) pulse_burst();
    chk("R4 short count holds", sw_sel, 1);
    pulse_burst();
    chk("R4 short count done", sw_sel, 0);
    pulse_stage(); pulse_stage(); pulse_stage();
    chk("R5 single rep final", pat_sel, 4);
    do_restart();
  endtask

  initial begin
    t_reset();
    t_full_entry();
    t_timeout_ts1();
    t_tmo_disabled();
    t_short_burst();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule